// File: doc/BRIEF.md
# Power-Up Configuration Restore Sequencer

This block brings a register bank back to life after power is applied. It starts with the power outputs floating. When any supply is present it pulls the outputs weakly low. It then waits for the undervoltage lockout to clear. After that it reads every nonvolatile location in turn and places each value in a shadow (staging) copy of the bank. The live copy, which steers the rest of the chip, is left alone during this time. Only after the final location has arrived does the sequencer fire one transfer strobe, which copies the whole shadow copy into the live copy in a single edge.

While the bank is not yet trustworthy, a busy flag tells the bus slave to refuse every transfer with a NACK. A host command re-runs the same restore at any time, so a bad set of edits can be discarded in favour of the stored defaults. The live settings stay in force until the new transfer strobe. The storage timing and the bus protocol sit in other blocks; here they are a request/valid read port and a single busy flag.

Top module: `cfg_restore_seq`

## Requirements
- R1: While `supply_ok` is low, `pout_mode` reads 2'b00 (outputs floating) one cycle later, `nvm_req` is low and `cfg_busy` is high.
- R2: With a supply present and no configuration yet transferred, `pout_mode` reads 2'b01 (weak pull-down).
- R3: No read is requested (`nvm_req` low) in any cycle after one in which `lockout_clr` was sampled low.
- R4: A restore reads addresses 0 up to DEPTH-1 in rising order, each accepted exactly once. The value accepted at address i lands in live slot i, at bits [i*DATA_W +: DATA_W] of `active_cfg`.
- R5: The read address holds its value in every cycle where a request is pending and `nvm_valid` is low.
- R6: `active_cfg` changes only on the edge that ends a `commit_pulse` cycle. `commit_pulse` is high for exactly one cycle, and that cycle directly follows the last accepted read.
- R7: `cfg_busy` is high from reset until the cycle after `commit_pulse`, and it is low from then on until a new restore begins.
- R8: After a transfer strobe, `pout_mode` reads 2'b10 (driven by configuration), and it keeps that value while a host-requested restore runs.
- R9: `reload_req`, sampled high once the bank is configured or while a restore is running, restarts reading at address 0 and raises `cfg_busy` on the next cycle.
- R10: When `lockout_clr` falls during a restore, reading stops, `pout_mode` returns to 2'b01 and `cfg_busy` stays high. When it rises again, reading restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Some supply has reached the presence level |
| lockout_clr | input | 1 | Main supply is above the undervoltage lockout |
| reload_req | input | 1 | Host request to restore from nonvolatile storage |
| nvm_req | output | 1 | Read request to the storage port |
| nvm_addr | output | $clog2(DEPTH) | Address of the pending read |
| nvm_valid | input | 1 | Read data valid; accepts the current address |
| nvm_data | input | DATA_W | Read data |
| commit_pulse | output | 1 | One-cycle strobe that moves the shadow copy to the live copy |
| cfg_busy | output | 1 | Bank not ready; the bus slave must NACK |
| pout_mode | output | 2 | Default power-output state: 00 float, 01 weak low, 10 configured |
| active_cfg | output | DEPTH*DATA_W | Live configuration, slot i at bits [i*DATA_W +: DATA_W] |

## Verification
Restores are run in three ways: with data returned every cycle, with two idle cycles between reads, and with a different data seed on each pass. The unstalled run fixes the cycle count and the position of the strobe. The stalled run shows that only `nvm_valid` moves the address, and a changed seed shows that the live copy keeps the old values until the strobe. Host restarts are issued both after configuration and partway through a restore, and lockout and supply are dropped in the middle. These cases separate a restart from address 0 from a resume, and a weak-low fallback from a floating one.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [2:0] {
    SEQ_OFF    = 3'd0,
    SEQ_WEAK   = 3'd1,
    SEQ_LOAD   = 3'd2,
    SEQ_COMMIT = 3'd3,
    SEQ_DONE   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    POUT_FLOAT = 2'b00,
    POUT_WEAK  = 2'b01,
    POUT_CFG   = 2'b10
  } pout_mode_e;
endpackage

// File: rtl/crs_reset_sync.sv
module crs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/crs_addr_ctr.sv
module crs_addr_ctr #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  assign last = (addr_q == AW'(DEPTH - 1));

  always_comb begin
    addr_en = clr | (inc & ~last);
    addr_d  = clr ? '0 : addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/crs_latch_bank.sv
module crs_latch_bank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stage_we,
  input  logic [AW-1:0]           stage_addr,
  input  logic [DATA_W-1:0]       stage_data,
  input  logic                    commit,
  output logic [DEPTH*DATA_W-1:0] live
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [DATA_W-1:0] shadow_q, live_q;
    logic              shadow_en;

    assign shadow_en = stage_we && (stage_addr == AW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shadow_q <= '0;
      else if (shadow_en) shadow_q <= stage_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      live_q <= '0;
      else if (commit) live_q <= shadow_q;
    end

    assign live[s*DATA_W +: DATA_W] = live_q;
  end
endmodule

// File: rtl/crs_seq_fsm.sv
module crs_seq_fsm
  import crs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       lockout_clr,
  input  logic       reload_req,
  input  logic       nvm_valid,
  input  logic       addr_last,
  output logic       nvm_req,
  output logic       addr_clr,
  output logic       load_go,
  output logic       commit_pulse,
  output logic       cfg_busy,
  output logic [1:0] pout_mode
);
  seq_state_e state_q, state_d;
  logic       cfgd_q, cfgd_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = SEQ_OFF;
    end else begin
      case (state_q)
        SEQ_OFF:    state_d = SEQ_WEAK;
        SEQ_WEAK:   if (lockout_clr) state_d = SEQ_LOAD;
        SEQ_LOAD: begin
          if (!lockout_clr)                state_d = SEQ_WEAK;
          else if (reload_req)             state_d = SEQ_LOAD;
          else if (nvm_valid && addr_last) state_d = SEQ_COMMIT;
        end
        SEQ_COMMIT: state_d = lockout_clr ? SEQ_DONE : SEQ_WEAK;
        SEQ_DONE: begin
          if (!lockout_clr)    state_d = SEQ_WEAK;
          else if (reload_req) state_d = SEQ_LOAD;
        end
        default:    state_d = SEQ_OFF;
      endcase
    end
  end

  always_comb begin
    load_go  = (state_q == SEQ_LOAD) && supply_ok && lockout_clr &&
               !reload_req && nvm_valid;
    addr_clr = (state_q != SEQ_LOAD) || !supply_ok || !lockout_clr || reload_req;
    commit_pulse = (state_q == SEQ_COMMIT);
    nvm_req  = (state_q == SEQ_LOAD);
    cfg_busy = (state_q != SEQ_DONE);
    if ((state_d == SEQ_OFF) || (state_d == SEQ_WEAK)) cfgd_d = 1'b0;
    else if (commit_pulse)                              cfgd_d = 1'b1;
    else                                                cfgd_d = cfgd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
      cfgd_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cfgd_q  <= cfgd_d;
    end
  end

  always_comb begin
    if (state_q == SEQ_OFF) pout_mode = POUT_FLOAT;
    else if (cfgd_q)        pout_mode = POUT_CFG;
    else                    pout_mode = POUT_WEAK;
  end
endmodule

// File: rtl/cfg_restore_seq.sv
module cfg_restore_seq #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    supply_ok,
  input  logic                    lockout_clr,
  input  logic                    reload_req,
  output logic                    nvm_req,
  output logic [AW-1:0]           nvm_addr,
  input  logic                    nvm_valid,
  input  logic [DATA_W-1:0]       nvm_data,
  output logic                    commit_pulse,
  output logic                    cfg_busy,
  output logic [1:0]              pout_mode,
  output logic [DEPTH*DATA_W-1:0] active_cfg
);
  logic rst_core_n;
  logic addr_clr, load_go, addr_last;

  crs_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  crs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n),
    .supply_ok(supply_ok), .lockout_clr(lockout_clr), .reload_req(reload_req),
    .nvm_valid(nvm_valid), .addr_last(addr_last),
    .nvm_req(nvm_req), .addr_clr(addr_clr), .load_go(load_go),
    .commit_pulse(commit_pulse), .cfg_busy(cfg_busy), .pout_mode(pout_mode)
  );

  crs_addr_ctr #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_core_n),
    .clr(addr_clr), .inc(load_go),
    .addr(nvm_addr), .last(addr_last)
  );

  crs_latch_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n),
    .stage_we(load_go), .stage_addr(nvm_addr), .stage_data(nvm_data),
    .commit(commit_pulse), .live(active_cfg)
  );
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    supply_ok,
  input logic                    lockout_clr,
  input logic                    reload_req,
  input logic                    nvm_req,
  input logic [AW-1:0]           nvm_addr,
  input logic                    nvm_valid,
  input logic                    commit_pulse,
  input logic                    cfg_busy,
  input logic [1:0]              pout_mode,
  input logic [DEPTH*DATA_W-1:0] active_cfg
);
  logic accept_mid;
  assign accept_mid = nvm_req && nvm_valid && supply_ok && lockout_clr &&
                      !reload_req && (nvm_addr != AW'(DEPTH - 1));

  assert_float_no_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (pout_mode == 2'b00) && !nvm_req && cfg_busy);

  assert_no_read_in_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lockout_clr |=> !nvm_req);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_mid |=> nvm_addr == $past(nvm_addr) + AW'(1));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req && !nvm_valid && supply_ok && lockout_clr && !reload_req)
      |=> $stable(nvm_addr));

  assert_live_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> $stable(active_cfg));

  assert_commit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && supply_ok && lockout_clr) |=> !cfg_busy);

  assert_busy_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req |-> cfg_busy);
endmodule

bind cfg_restore_seq crs_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lockout_clr(lockout_clr),
  .reload_req(reload_req), .nvm_req(nvm_req), .nvm_addr(nvm_addr),
  .nvm_valid(nvm_valid), .commit_pulse(commit_pulse), .cfg_busy(cfg_busy),
  .pout_mode(pout_mode), .active_cfg(active_cfg)
);

// File: tb/sim_cfg_restore_seq.sv
`timescale 1ns/1ps
module sim_cfg_restore_seq;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 8;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = DEPTH * DATA_W;

  logic clk = 1'b0;
  logic rst_n, supply_ok, lockout_clr, reload_req, nvm_valid;
  logic [DATA_W-1:0] nvm_data;
  logic nvm_req, commit_pulse, cfg_busy;
  logic [AW-1:0] nvm_addr;
  logic [1:0] pout_mode;
  logic [CW-1:0] active_cfg;

  int n_run = 0, n_fail = 0;
  int gap = 0, gap_cnt = 0, seed = 0;
  logic [CW-1:0] exp_live;

  always #5 clk = ~clk;

  cfg_restore_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lockout_clr(lockout_clr),
    .reload_req(reload_req), .nvm_req(nvm_req), .nvm_addr(nvm_addr),
    .nvm_valid(nvm_valid), .nvm_data(nvm_data), .commit_pulse(commit_pulse),
    .cfg_busy(cfg_busy), .pout_mode(pout_mode), .active_cfg(active_cfg)
  );

  function automatic logic [DATA_W-1:0] pat(input int sd, input int idx);
    return DATA_W'(sd * 37 + idx * 13 + 90);
  endfunction

  function automatic logic [CW-1:0] image(input int sd);
    logic [CW-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i*DATA_W +: DATA_W] = pat(sd, i);
    return v;
  endfunction

  // storage model: answers a pending request after `gap` idle cycles
  always @(negedge clk) begin
    if (nvm_req) begin
      nvm_valid = (gap_cnt >= gap);
      gap_cnt   = nvm_valid ? 0 : gap_cnt + 1;
    end else begin
      nvm_valid = 1'b0;
      gap_cnt   = 0;
    end
    nvm_data = pat(seed, int'(nvm_addr));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // count n accepted reads from the current point, checking their order
  task automatic take_reads(input int n, inout int next_idx);
    int got = 0;
    for (int t = 0; t < 400 && got < n; t++) begin
      @(negedge clk); #1;
      if (nvm_req && nvm_valid) begin
        chk(nvm_addr == AW'(next_idx), "R4", "partial read order", CW'(nvm_addr), CW'(next_idx));
        next_idx++; got++;
      end
    end
  endtask

  // run a full restore to its strobe and check the transfer
  task automatic run_restore(input int sd, input int g);
    int idx = 0, prev_addr = -1;
    bit prev_stall = 0, seen = 0;
    seed = sd; gap = g;
    for (int t = 0; t < 1000 && !seen; t++) begin
      @(negedge clk); #1;
      if (prev_stall)
        chk(int'(nvm_addr) == prev_addr, "R5", "address moved while stalled", CW'(nvm_addr), CW'(prev_addr));
      prev_stall = nvm_req && !nvm_valid;
      prev_addr  = int'(nvm_addr);
      chk(active_cfg == exp_live, "R6", "live copy changed before strobe", active_cfg, exp_live);
      chk(cfg_busy, "R7", "busy during restore", CW'(cfg_busy), 1);
      if (commit_pulse) begin
        seen = 1;
        chk(idx == DEPTH, "R6", "strobe before last read", CW'(idx), CW'(DEPTH));
      end else if (nvm_req && nvm_valid) begin
        chk(nvm_addr == AW'(idx), "R4", "read order", CW'(nvm_addr), CW'(idx));
        idx++;
      end
    end
    chk(seen, "R6", "no strobe seen", CW'(seen), 1);
    exp_live = image(sd);
    @(negedge clk); #1;
    chk(!commit_pulse, "R6", "strobe longer than one cycle", CW'(commit_pulse), 0);
    chk(active_cfg == exp_live, "R4", "live copy after strobe", active_cfg, exp_live);
    chk(!cfg_busy, "R7", "busy after strobe", CW'(cfg_busy), 0);
    chk(pout_mode == 2'b10, "R8", "mode after strobe", CW'(pout_mode), 2);
  endtask

  task automatic t_reset();
    rst_n = 0; supply_ok = 0; lockout_clr = 0; reload_req = 0;
    nvm_valid = 0; nvm_data = '0; exp_live = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk); #1;
    chk(pout_mode == 2'b00, "R1", "mode without supply", CW'(pout_mode), 0);
    chk(!nvm_req && cfg_busy, "R1", "req/busy without supply", CW'({nvm_req, cfg_busy}), 1);
    chk(active_cfg == '0, "R6", "live copy at reset", active_cfg, '0);
  endtask

  task automatic t_powerup_plain();
    supply_ok = 1;
    @(posedge clk); #1;
    chk(pout_mode == 2'b01, "R2", "mode with supply", CW'(pout_mode), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk(!nvm_req, "R3", "read under lockout", CW'(nvm_req), 0);
    end
    lockout_clr = 1;
    @(posedge clk); #1;
    chk(nvm_req && nvm_addr == '0, "R4", "first read at 0", CW'({nvm_req, nvm_addr}), CW'({1'b1, AW'(0)}));
    run_restore(1, 0);
  endtask

  task automatic t_host_reload_stalled();
    repeat (3) @(negedge clk);
    #1 reload_req = 1;
    @(posedge clk); #1 reload_req = 0;
    chk(cfg_busy && nvm_addr == '0, "R9", "reload from configured", CW'({cfg_busy, nvm_addr}), CW'({1'b1, AW'(0)}));
    chk(pout_mode == 2'b10, "R8", "mode kept during reload", CW'(pout_mode), 2);
    run_restore(2, 2);
  endtask

  task automatic t_reload_midway();
    int nx = 0;
    @(negedge clk); #1 reload_req = 1;
    @(posedge clk); #1 reload_req = 0;
    seed = 3; gap = 0;
    take_reads(3, nx);
    reload_req = 1;
    @(posedge clk); #1 reload_req = 0;
    chk(nvm_addr == '0 && nvm_req, "R9", "restart mid-restore", CW'({nvm_req, nvm_addr}), CW'({1'b1, AW'(0)}));
    run_restore(4, 1);
  endtask

  task automatic t_lockout_drop();
    int nx = 0;
    @(negedge clk); #1 reload_req = 1;
    @(posedge clk); #1 reload_req = 0;
    seed = 5; gap = 0;
    take_reads(4, nx);
    lockout_clr = 0;
    @(posedge clk); #1;
    chk(!nvm_req && cfg_busy, "R10", "reads stop on lockout", CW'({nvm_req, cfg_busy}), 1);
    chk(pout_mode == 2'b01, "R10", "weak low on lockout", CW'(pout_mode), 1);
    repeat (4) @(negedge clk); #1;
    chk(active_cfg == exp_live, "R6", "live copy kept under lockout", active_cfg, exp_live);
    lockout_clr = 1;
    @(posedge clk); #1;
    chk(nvm_req && nvm_addr == '0, "R10", "restart at 0 after lockout", CW'({nvm_req, nvm_addr}), CW'({1'b1, AW'(0)}));
    run_restore(6, 0);
  endtask

  task automatic t_supply_drop();
    @(negedge clk); #1 supply_ok = 0;
    @(posedge clk); #1;
    chk(pout_mode == 2'b00 && !nvm_req, "R1", "float after supply loss", CW'({pout_mode, nvm_req}), 0);
    chk(cfg_busy, "R1", "busy after supply loss", CW'(cfg_busy), 1);
    supply_ok = 1;
    @(posedge clk); #1;
    chk(pout_mode == 2'b01, "R2", "weak low on supply return", CW'(pout_mode), 1);
    run_restore(7, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_powerup_plain();
        t_host_reload_stalled();
        t_reload_midway();
        t_lockout_drop();
        t_supply_drop();
      end
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: act=timeout exp=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule